// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block watches for a stalled program. A free-running prescaler divides the system clock by 2^PRE_W, which is 2^15 by default, and produces one base tick per period. A second counter counts those ticks against a limit chosen by a 2-bit rate select. If the limit is passed before software services the block, the block raises a one-cycle reset request and then starts a new period.

Software services the watchdog through a byte write port with two writes. The first write carries the arm key 0x55. The second carries the fire key 0xAA, and it clears the tick counter. Any number of other writes may fall between the two keys. A service only clears the tick stage. The prescaler keeps running, so the real time-out can run up to one base period past the nominal value, and never falls short of it.

Top module: `wdt_keyed`

## Requirements
- R1: After synchronous reset, `rst_req` is 0 and the block is not armed, so a lone 0xAA written right after reset does not move the first time-out.
- R2: With `rate_sel` = s held constant and no service, the first `rst_req` pulse after reset release comes on clock edge (4^s + 1) * 2^PRE_W, counting the first edge after release as edge 1.
- R3: `rst_req` stays high for exactly one clock. The period then restarts, so the next pulse comes (4^s + 1) * 2^PRE_W edges later.
- R4: A write of 0x55 followed by a write of 0xAA clears the time-out. If the 0xAA is sampled on edge c, the next pulse comes on edge (floor(c / 2^PRE_W) + 1) * 2^PRE_W + 4^s * 2^PRE_W.
- R5: A write of 0xAA while the block is not armed has no effect on the time-out.
- R6: A write of any value other than 0x55 or 0xAA leaves the armed state as it was.
- R7: A 0xAA that clears the counter also disarms the block, so a second 0xAA without a new 0x55 has no effect.
- R8: While `en` is low, `rst_req` stays 0 and the tick count is held at zero. The first edge with `en` high counts as a service at the last low edge.
- R9: The prescaler is never cleared by a service. The time from a clear on edge c to the next pulse is greater than 4^s * 2^PRE_W and at most (4^s + 1) * 2^PRE_W edges.
- R10: If a clearing 0xAA is sampled on the same edge as an expiring tick, the clear wins and no pulse is raised on that edge.
- R11: Driving `en` low disarms the block. A 0xAA after `en` returns high, with no new 0x55, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Watchdog enable; low holds the tick count and the armed state at zero |
| rate_sel | input | 2 | Time-out select: limit of 4^rate_sel base ticks |
| wr_stb | input | 1 | Service-register write strobe |
| wr_data | input | 8 | Service-register write data (keys 0x55, 0xAA) |
| rst_req | output | 1 | One-cycle registered reset request on time-out |

## Verification
The only observable output is the reset-request pulse. A wrong internal state therefore shows up as a pulse on the wrong edge. A stuck or wrongly cleared armed flag moves the next pulse by whole base periods, and that shift appears within one time-out window. A wrong prescaler phase or a cleared prescaler shifts the pulse by less than one base period. The bench uses a small prescaler, sweeps the service edge across every phase of the base period, and checks each pulse on its exact edge with nothing earlier.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam logic [7:0] ARM_KEY_DEF  = 8'h55;
  localparam logic [7:0] FIRE_KEY_DEF = 8'hAA;
  localparam int         STEP_SHIFT_DEF = 2;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 15
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + PRE_W'(1);
  end

  assign tick = &pre_q;

  // R9: the prescaler advances every cycle and nothing but reset clears it
  a_r9_free_running: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pre_q == $past(pre_q) + PRE_W'(1));
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm #(
  parameter logic [7:0] ARM_KEY  = wdt_pkg::ARM_KEY_DEF,
  parameter logic [7:0] FIRE_KEY = wdt_pkg::FIRE_KEY_DEF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       clear
);
  logic armed_q;
  logic is_arm, is_fire;

  assign is_arm  = wr_stb && (wr_data == ARM_KEY);
  assign is_fire = wr_stb && (wr_data == FIRE_KEY);
  assign clear   = en && armed_q && is_fire;

  always_ff @(posedge clk) begin
    if (rst || !en)   armed_q <= 1'b0;
    else if (is_arm)  armed_q <= 1'b1;
    else if (is_fire) armed_q <= 1'b0;
  end

  // R7: a completed clear leaves the block disarmed
  a_r7_fire_disarms: assert property (@(posedge clk) disable iff (rst)
    clear |=> !armed_q);
  // R11: a disabled cycle leaves the block disarmed
  a_r11_disable_disarms: assert property (@(posedge clk) disable iff (rst)
    !en |=> !armed_q);
  // R6: a non-key write does not change the armed state
  a_r6_other_keeps: assert property (@(posedge clk) disable iff (rst)
    (en && wr_stb && !is_arm && !is_fire) |=> $stable(armed_q));
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
  parameter int SEL_W      = 2,
  parameter int STEP_SHIFT = wdt_pkg::STEP_SHIFT_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic             expire
);
  localparam int NUM_RATES = 1 << SEL_W;
  localparam int CNT_W     = STEP_SHIFT * (NUM_RATES - 1) + 1;

  logic [CNT_W-1:0] cnt_q, limit;
  logic             expire_q;

  always_comb begin
    limit = '0;
    for (int i = 0; i < NUM_RATES; i++)
      if (sel == SEL_W'(i)) limit[STEP_SHIFT*i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (clear) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q >= limit) begin
          cnt_q    <= '0;
          expire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
      end
    end
  end

  assign expire = expire_q;

  // R2: a time-out only follows an enabled base tick
  a_r2_expire_on_tick: assert property (@(posedge clk) disable iff (rst)
    expire |-> ($past(tick) && $past(en)));
  // R8: no time-out follows a disabled cycle
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !expire);
  // R10: a clear blocks a time-out on the same edge
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clear |=> (!expire && cnt_q == '0));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int         PRE_W      = 15,
  parameter int         SEL_W      = 2,
  parameter int         STEP_SHIFT = wdt_pkg::STEP_SHIFT_DEF,
  parameter logic [7:0] ARM_KEY    = wdt_pkg::ARM_KEY_DEF,
  parameter logic [7:0] FIRE_KEY   = wdt_pkg::FIRE_KEY_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             wr_stb,
  input  logic [7:0]       wr_data,
  output logic             rst_req
);
  logic tick, clear;

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tick(tick)
  );

  wdt_key_fsm #(.ARM_KEY(ARM_KEY), .FIRE_KEY(FIRE_KEY)) u_key (
    .clk(clk), .rst(rst), .en(en),
    .wr_stb(wr_stb), .wr_data(wr_data), .clear(clear)
  );

  wdt_tick_counter #(.SEL_W(SEL_W), .STEP_SHIFT(STEP_SHIFT)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .clear(clear),
    .sel(rate_sel), .expire(rst_req)
  );

  // R3: the reset request lasts one clock
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R1: no request in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !rst_req);
endmodule

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  localparam int PRE_W = 3;
  localparam int BASE  = 1 << PRE_W;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b1;
  logic [1:0] rate_sel = 2'd0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rst_req;
  int         edge_cnt;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  wdt_keyed #(.PRE_W(PRE_W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .rate_sel(rate_sel),
    .wr_stb(wr_stb), .wr_data(wr_data), .rst_req(rst_req)
  );

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (rst) edge_cnt <= 0;
    else     edge_cnt <= edge_cnt + 1;
  end

  function automatic int lim(input int s);
    return 1 << (2 * s);
  endfunction

  function automatic int next_to(input int c, input int s);
    return ((c / BASE) + 1) * BASE + lim(s) * BASE;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int s);
    @(negedge clk);
    rst = 1'b1; en = 1'b1; wr_stb = 1'b0; rate_sel = 2'(s);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_edge(input int n);
    while (edge_cnt < n) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d, output int e);
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk);
    e = edge_cnt;
    wr_stb = 1'b0;
  endtask

  task automatic expect_pulse(input int t, input string req);
    int early = -1;
    while (edge_cnt < t) begin
      if (rst_req && early < 0) early = edge_cnt;
      @(negedge clk);
    end
    check(early < 0, req, early, -1);
    check(rst_req == 1'b1, req, int'(rst_req), 1);
    @(negedge clk);
    check(rst_req == 1'b0, req, int'(rst_req), 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run ended)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int e, c, t;

    // R1: reset state, lone fire key ignored after reset
    do_reset(0);
    check(rst_req == 1'b0, "R1", int'(rst_req), 0);
    wait_edge(3);
    put(8'hAA, e);
    expect_pulse(2 * BASE, "R1");

    // R2 / R3: every rate, two consecutive periods
    for (int s = 0; s < 4; s++) begin
      do_reset(s);
      t = (lim(s) + 1) * BASE;
      expect_pulse(t, "R2");
      expect_pulse(2 * t, "R3");
    end

    // R4 / R9: service at every prescaler phase (R10 when c lands on a tick)
    for (int ph = 0; ph < BASE; ph++) begin
      do_reset(0);
      wait_edge(4 + ph);
      put(8'h55, e);
      put(8'hAA, c);
      t = next_to(c, 0);
      check((t - c) > lim(0) * BASE && (t - c) <= (lim(0) + 1) * BASE,
            "R9", t - c, (lim(0) + 1) * BASE);
      expect_pulse(t, "R4");
    end

    // R10: clear on the very edge that would expire
    do_reset(0);
    wait_edge(2 * BASE - 3);
    put(8'h55, e);
    wait_edge(2 * BASE - 1);
    put(8'hAA, c);
    check(c == 2 * BASE, "R10", c, 2 * BASE);
    expect_pulse(next_to(c, 0), "R10");

    // R5: fire key without arm, mid-period
    do_reset(1);
    wait_edge(20);
    put(8'hAA, e);
    expect_pulse((lim(1) + 1) * BASE, "R5");

    // R6: other writes between the keys keep the armed state
    do_reset(1);
    wait_edge(20);
    put(8'h55, e);
    put(8'h12, e);
    put(8'h00, e);
    put(8'hFF, e);
    put(8'hAA, c);
    expect_pulse(next_to(c, 1), "R6");

    // R7: second fire key without a new arm is ignored
    do_reset(1);
    wait_edge(9);
    put(8'h55, e);
    put(8'hAA, c);
    wait_edge(30);
    put(8'hAA, e);
    expect_pulse(next_to(c, 1), "R7");

    // R8 / R11: enable low holds the count and drops the armed state
    do_reset(0);
    wait_edge(5);
    put(8'h55, e);
    en = 1'b0;
    t = -1;
    while (edge_cnt < 40) begin
      @(negedge clk);
      if (rst_req && t < 0) t = edge_cnt;
    end
    check(t < 0, "R8", t, -1);
    en = 1'b1;
    c = 40;
    wait_edge(48);
    put(8'hAA, e);
    expect_pulse(next_to(c, 0), "R11");
    expect_pulse(next_to(c, 0) + (lim(0) + 1) * BASE, "R8");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule